// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves data between system memory and a device-side word stream under the control of a list of descriptors held in memory. Software programs a list base address, the address of a small completion area and a transfer direction through a register file of 32-bit words. It then sets the go bit. The engine walks the list one 16-byte descriptor at a time. It moves each buffer word by word, either from memory to the outgoing stream or from the incoming stream to memory. Separate byte counters are kept for the device side and for the memory side.

When the list ends, or when a stop requested by software takes effect, the engine writes all-ones words into the completion area and then drops its busy flag. Software can therefore poll memory to learn that every data write has landed before it trusts the registers. A failed memory response halts the engine at once, sets a fault flag and suppresses the completion write. The memory port is a single-outstanding request/response master. Both device paths are ready/valid streams, with one 32-bit word per beat.

Top module: `sgdma_engine`

## Requirements
- R1: After reset, the control/status word, both byte counters and the current-address word read 0, and neither mem_req nor dev_tx_valid is asserted.
- R2: Register word k is at byte address 4*k. Words 0 (timing), 1 (list base low), 2 (list base high) and 8 (completion address) read back what was written. Word 4 (current address high) always reads 0.
- R3: Control/status word 7 has these bits: go at bit 0 (reads 0), stop at bit 1, direction at bit 2, busy at bit 3 and fault at bit 4. A go write is accepted only while busy is 0. An accepted go sets busy and loads the direction. A go written while busy leaves the direction and the transfer unchanged.
- R4: A descriptor is four 32-bit memory words, each stored in big-endian byte order. The word at offset +4 holds the buffer address. The word at offset +12 holds the length in bytes in bits 15:0 and the end-of-list flag in bit 31. A length of 0 means 65536 bytes.
- R5: With direction 0, the engine reads the buffer words from memory in ascending address order and sends each one unchanged on the outgoing stream. With direction 1, it takes words from the incoming stream and writes them to ascending buffer addresses.
- R6: Descriptors are processed in order from the list base, 16 bytes apart. No descriptor after the one with the end-of-list flag is used.
- R7: After the last data word, the engine writes CMPL_WORDS words of 0xFFFFFFFF starting at the completion address, then clears busy.
- R8: The device count (word 5) grows by 4 per stream beat. The memory count (word 6) grows by 4 per completed memory data access. Both clear on an accepted go, and they are equal whenever the engine halts without a fault.
- R9: A stop written while busy reads back as 1 until the engine halts at a word boundary. The halt includes the completion write, after which stop and busy read 0. A stop written while idle is ignored and reads 0.
- R10: A memory error response sets fault, clears busy and skips the completion write. Fault clears on the next write to word 7 with go at 0.
- R11: After a transfer, the current address (word 3) holds the byte address just past the last word moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address (word index times 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until mem_rvalid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory response for the pending request |
| mem_rdata | input | 32 | Memory read data |
| mem_rerr | input | 1 | Memory response carries an error |
| dev_tx_valid | output | 1 | Outgoing stream word valid |
| dev_tx_data | output | 32 | Outgoing stream word |
| dev_tx_ready | input | 1 | Device accepts outgoing word |
| dev_rx_valid | input | 1 | Incoming stream word valid |
| dev_rx_data | input | 32 | Incoming stream word |
| dev_rx_ready | output | 1 | Engine accepts incoming word |

## Verification
A table of transfers covers both directions, one-descriptor and two-descriptor lists, unequal buffer lengths and stalling or free-running stream partners. It separates correct list walking and end-of-list handling from plain buffer copying, and shows whether the counters and current address follow what actually moved. A zero-length descriptor at a high address tells the 65536-byte meaning apart from a truncated length, and it checks the byte swap on a real address. A go written while busy, a stop written while busy or idle, and an error in the middle of a buffer each isolate one control path. Each of these is judged by the words seen on the stream, in memory and in the completion area.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned BEAT_BYTES = WORD_BITS / 8;

  localparam logic [3:0] RIDX_TIMING  = 4'd0;
  localparam logic [3:0] RIDX_LIST_LO = 4'd1;
  localparam logic [3:0] RIDX_LIST_HI = 4'd2;
  localparam logic [3:0] RIDX_CUR_LO  = 4'd3;
  localparam logic [3:0] RIDX_CUR_HI  = 4'd4;
  localparam logic [3:0] RIDX_DEVCNT  = 4'd5;
  localparam logic [3:0] RIDX_MEMCNT  = 4'd6;
  localparam logic [3:0] RIDX_CSR     = 4'd7;
  localparam logic [3:0] RIDX_DONE    = 4'd8;

  localparam int unsigned CSR_GO    = 0;
  localparam int unsigned CSR_HALT  = 1;
  localparam int unsigned CSR_TOMEM = 2;
  localparam int unsigned CSR_BUSY  = 3;
  localparam int unsigned CSR_FAULT = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_DADDR, S_DLEN, S_MRD, S_TX, S_RX, S_MWR, S_CMPL
  } seq_state_t;

  // Reverse byte order of a descriptor word.
  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Buffer length in bytes; a zero field stands for 65536.
  function automatic logic [16:0] desc_len_bytes(input logic [15:0] f);
    return (f == 16'd0) ? 17'h10000 : {1'b0, f};
  endfunction
endpackage

// File: rtl/sgdma_bytecnt.sv
module sgdma_bytecnt
  import sgdma_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (beat)  count <= count + CNT_W'(BEAT_BYTES);
  end
endmodule

// File: rtl/sgdma_csr.sv
module sgdma_csr
  import sgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] cur_addr,
  input  logic [31:0] dev_cnt,
  input  logic [31:0] mem_cnt,
  input  logic        evt_halt,
  input  logic        evt_err,
  output logic        start_go,
  output logic        stop_req,
  output logic        to_mem,
  output logic        busy,
  output logic [31:0] list_ptr,
  output logic [31:0] done_addr
);
  logic [3:0]  idx;
  logic        csr_wr, fault_q;
  logic [31:0] timing_q, list_hi_q;
  logic [1:0]  unused_low;

  assign idx        = reg_addr[5:2];
  assign unused_low = reg_addr[1:0];
  assign csr_wr     = reg_we && (idx == RIDX_CSR);
  assign start_go   = csr_wr && reg_wdata[CSR_GO] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing_q <= '0; list_ptr <= '0; list_hi_q <= '0; done_addr <= '0;
      busy <= 1'b0; stop_req <= 1'b0; to_mem <= 1'b0; fault_q <= 1'b0;
    end else begin
      if (reg_we && idx == RIDX_TIMING)  timing_q  <= reg_wdata;
      if (reg_we && idx == RIDX_LIST_LO) list_ptr  <= reg_wdata;
      if (reg_we && idx == RIDX_LIST_HI) list_hi_q <= reg_wdata;
      if (reg_we && idx == RIDX_DONE)    done_addr <= reg_wdata;
      if (start_go) begin
        busy    <= 1'b1;
        fault_q <= 1'b0;
        to_mem  <= reg_wdata[CSR_TOMEM];
      end else if (csr_wr && !reg_wdata[CSR_GO]) begin
        fault_q <= 1'b0;
        if (!busy) to_mem <= reg_wdata[CSR_TOMEM];
      end
      if (csr_wr && reg_wdata[CSR_HALT] && busy) stop_req <= 1'b1;
      if (evt_halt || evt_err) begin
        busy     <= 1'b0;
        stop_req <= 1'b0;
      end
      if (evt_err) fault_q <= 1'b1;
    end
  end

  always_comb begin
    case (idx)
      RIDX_TIMING:  reg_rdata = timing_q;
      RIDX_LIST_LO: reg_rdata = list_ptr;
      RIDX_LIST_HI: reg_rdata = list_hi_q;
      RIDX_CUR_LO:  reg_rdata = cur_addr;
      RIDX_DEVCNT:  reg_rdata = dev_cnt;
      RIDX_MEMCNT:  reg_rdata = mem_cnt;
      RIDX_CSR:     reg_rdata = {27'd0, fault_q, busy, to_mem, stop_req, 1'b0};
      RIDX_DONE:    reg_rdata = done_addr;
      default:      reg_rdata = '0;
    endcase
  end

  // R9
  halt_drops_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_req) |-> $fell(busy));
  // R3
  go_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(csr_wr && reg_wdata[CSR_GO]));
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int unsigned CMPL_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_go,
  input  logic        to_mem,
  input  logic        stop_req,
  input  logic [31:0] list_ptr,
  input  logic [31:0] done_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rerr,
  output logic        dev_tx_valid,
  output logic [31:0] dev_tx_data,
  input  logic        dev_tx_ready,
  input  logic        dev_rx_valid,
  input  logic [31:0] dev_rx_data,
  output logic        dev_rx_ready,
  output logic [31:0] cur_addr,
  output logic        evt_mem_beat,
  output logic        evt_dev_beat,
  output logic        evt_halt,
  output logic        evt_err
);
  localparam int unsigned CW_W = $clog2(CMPL_WORDS) + 1;
  localparam logic [CW_W-1:0] CW_LAST = CW_W'(CMPL_WORDS - 1);

  seq_state_t      st, adv_next;
  logic [31:0]     dptr, data_q, len_word;
  logic [16:0]     remain;
  logic            eol, mem_ack, mem_bad, last, beat_done;
  logic [CW_W-1:0] cw;

  assign mem_ack   = mem_req && mem_rvalid;
  assign mem_bad   = mem_ack && mem_rerr;
  assign last      = (remain == 17'(BEAT_BYTES));
  assign len_word  = bswap32(mem_rdata);
  assign beat_done = (st == S_TX && dev_tx_ready) || (st == S_MWR && mem_ack && !mem_rerr);

  assign mem_req      = st inside {S_DADDR, S_DLEN, S_MRD, S_MWR, S_CMPL};
  assign mem_we       = st inside {S_MWR, S_CMPL};
  assign mem_wdata    = (st == S_CMPL) ? '1 : data_q;
  assign dev_tx_valid = (st == S_TX);
  assign dev_tx_data  = data_q;
  assign dev_rx_ready = (st == S_RX);
  assign evt_mem_beat = mem_ack && !mem_rerr && (st inside {S_MRD, S_MWR});
  assign evt_dev_beat = (st == S_TX && dev_tx_ready) || (st == S_RX && dev_rx_valid);
  assign evt_err      = mem_bad;
  assign evt_halt     = (st == S_CMPL) && mem_ack && !mem_rerr && (cw == CW_LAST);

  always_comb begin
    case (st)
      S_DADDR: mem_addr = dptr + 32'd4;
      S_DLEN:  mem_addr = dptr + 32'd12;
      S_CMPL:  mem_addr = done_addr + (32'(cw) << 2);
      default: mem_addr = cur_addr;
    endcase
    if (last && eol)   adv_next = S_CMPL;
    else if (stop_req) adv_next = S_CMPL;
    else if (last)     adv_next = S_DADDR;
    else               adv_next = to_mem ? S_RX : S_MRD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dptr <= '0; cur_addr <= '0; data_q <= '0;
      remain <= '0; eol <= 1'b0; cw <= '0;
    end else if (mem_bad) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (start_go) begin
          dptr <= list_ptr; cw <= '0; st <= S_DADDR;
        end
        S_DADDR: if (mem_ack) begin
          cur_addr <= bswap32(mem_rdata); st <= S_DLEN;
        end
        S_DLEN: if (mem_ack) begin
          remain <= desc_len_bytes(len_word[15:0]);
          eol    <= len_word[31];
          st     <= stop_req ? S_CMPL : (to_mem ? S_RX : S_MRD);
        end
        S_MRD: if (mem_ack) begin
          data_q <= mem_rdata; st <= S_TX;
        end
        S_RX: if (dev_rx_valid) begin
          data_q <= dev_rx_data; st <= S_MWR;
        end else if (stop_req) st <= S_CMPL;
        S_CMPL: if (mem_ack) begin
          if (cw == CW_LAST) st <= S_IDLE;
          else cw <= cw + 1'b1;
        end
        default: ;
      endcase
      if (beat_done) begin
        cur_addr <= cur_addr + 32'(BEAT_BYTES);
        remain   <= remain - 17'(BEAT_BYTES);
        if (last) dptr <= dptr + 32'd16;
        st <= adv_next;
      end
    end
  end

  // R5
  one_path_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, dev_tx_valid, dev_rx_ready}));
  // R5
  tx_word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data));
  // R4
  mem_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int unsigned CMPL_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rerr,
  output logic        dev_tx_valid,
  output logic [31:0] dev_tx_data,
  input  logic        dev_tx_ready,
  input  logic        dev_rx_valid,
  input  logic [31:0] dev_rx_data,
  output logic        dev_rx_ready
);
  logic        start_go, stop_req, to_mem, busy;
  logic        evt_mem_beat, evt_dev_beat, evt_halt, evt_err;
  logic [31:0] list_ptr, done_addr, cur_addr, dev_cnt, mem_cnt;

  sgdma_csr u_csr (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .cur_addr, .dev_cnt, .mem_cnt, .evt_halt, .evt_err,
    .start_go, .stop_req, .to_mem, .busy, .list_ptr, .done_addr
  );

  sgdma_seq #(.CMPL_WORDS(CMPL_WORDS)) u_seq (
    .clk, .rst_n, .start_go, .to_mem, .stop_req, .list_ptr, .done_addr,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rvalid, .mem_rdata, .mem_rerr,
    .dev_tx_valid, .dev_tx_data, .dev_tx_ready, .dev_rx_valid, .dev_rx_data,
    .dev_rx_ready, .cur_addr, .evt_mem_beat, .evt_dev_beat, .evt_halt, .evt_err
  );

  sgdma_bytecnt #(.CNT_W(32)) u_devcnt (
    .clk, .rst_n, .clear(start_go), .beat(evt_dev_beat), .count(dev_cnt));
  sgdma_bytecnt #(.CNT_W(32)) u_memcnt (
    .clk, .rst_n, .clear(start_go), .beat(evt_mem_beat), .count(mem_cnt));

  // R8
  counts_agree_at_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_halt |-> dev_cnt == mem_cnt);
  // R10
  fault_stops_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> !busy && !mem_req);
endmodule

// File: tb/tb_sgdma_engine.sv
`timescale 1ns/1ps
module tb_sgdma_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, dev_tx_valid, dev_rx_ready;
  logic [31:0] mem_addr, mem_wdata, dev_tx_data;
  logic mem_rvalid = 1'b0, mem_rerr = 1'b0, dev_tx_ready = 1'b0, dev_rx_valid = 1'b0;
  logic [31:0] mem_rdata = '0, dev_rx_data;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  logic busy_m = 1'b0, stall = 1'b0;
  int tx_n = 0, rx_n = 0;
  logic [31:0] tx_log [0:255];
  logic [31:0] tx_last = '0;

  // {stall, dir, ndesc, lenA, lenB}
  localparam logic [35:0] CASES [4] = '{
    {1'b0, 1'b0, 2'd1, 16'd16, 16'd0},
    {1'b1, 1'b0, 2'd2, 16'd12, 16'd8},
    {1'b0, 1'b1, 2'd1, 16'd20, 16'd0},
    {1'b1, 1'b1, 2'd2, 16'd4,  16'd32}};

  sgdma_engine dut (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [31:0] bsw(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = v[8*(3-b) +: 8];
    return r;
  endfunction

  assign dev_rx_data = 32'hBEEF_0000 + 32'(rx_n);

  // memory responder and stream partners
  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_rvalid <= 1'b0; mem_rerr <= 1'b0;
    if (!busy_m && mem_req && !mem_rvalid) busy_m <= 1'b1;
    else if (busy_m) begin
      busy_m <= 1'b0; mem_rvalid <= 1'b1;
      if (mem_addr == err_addr) mem_rerr <= 1'b1;
      else if (mem_we) begin
        if (mem_addr < 32'd4096) mem[mem_addr[11:2]] <= mem_wdata;
      end else
        mem_rdata <= (mem_addr < 32'd4096) ? mem[mem_addr[11:2]] : pat(mem_addr);
    end
    dev_tx_ready <= stall ? ~dev_tx_ready : 1'b1;
    dev_rx_valid <= stall ? ~dev_rx_valid : 1'b1;
    if (dev_tx_valid && dev_tx_ready) begin
      tx_log[tx_n[7:0]] <= dev_tx_data; tx_last <= dev_tx_data; tx_n <= tx_n + 1;
    end
    if (dev_rx_valid && dev_rx_ready) rx_n <= rx_n + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 6'(idx * 4); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk); reg_addr = 6'(idx * 4); #0.5; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin rd(7, v); n++; end while (v[3] && n < 100000);
  endtask

  task automatic start_xfer(input bit dir, input int nd, input logic [15:0] la, lb,
                            input logic [31:0] aa, ab);
    mem[1] = bsw(aa); mem[3] = bsw({(nd == 1), 15'd0, la});
    mem[5] = bsw(ab); mem[7] = bsw({1'b1, 15'd0, lb});
    mem[0] = 0; mem[2] = 0; mem[4] = 0; mem[6] = 0;
    for (int k = 64; k < 68; k++) mem[k] = 0;
    wr(1, 32'h0); wr(8, 32'h100);
    wr(7, {29'd0, dir, 2'b00});
    wr(7, {29'd0, dir, 2'b01});
  endtask

  task automatic cmpl_chk(input string tag, input logic [31:0] exp);
    for (int k = 64; k < 68; k++) chk(tag, mem[k], exp);
  endtask

  initial begin
    for (int w = 0; w < 1024; w++) mem[w] = pat(32'(w * 4));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    logic [31:0] v;
    int t0, r0, tot, nw;
    @(posedge rst_n);
    // R1 reset state
    rd(7, v); chk("R1 csr", v, 0);
    rd(5, v); chk("R1 devcnt", v, 0);
    rd(6, v); chk("R1 memcnt", v, 0);
    rd(3, v); chk("R1 cur", v, 0);
    chk("R1 idle ports", {31'd0, mem_req | dev_tx_valid}, 0);
    // R2 register map
    wr(0, 32'h0000_005A); rd(0, v); chk("R2 timing", v, 32'h5A);
    wr(2, 32'h0000_0012); rd(2, v); chk("R2 list hi", v, 32'h12);
    wr(8, 32'h0000_0ABC); rd(8, v); chk("R2 done", v, 32'hABC);
    rd(4, v); chk("R2 cur hi", v, 0);
    // R9 stop while idle ignored
    wr(7, 32'h2); rd(7, v); chk("R9 idle stop", v, 0);

    // table of transfers: R5 R6 R7 R8 R11
    for (int c = 0; c < 4; c++) begin
      logic [35:0] e;
      logic dir;
      int nd;
      logic [31:0] aa, ab;
      e = CASES[c];
      stall = e[35]; dir = e[34]; nd = int'(e[33:32]);
      aa = dir ? 32'h800 : 32'h400; ab = dir ? 32'hA00 : 32'h600;
      tot = int'(e[31:16]) + ((nd == 2) ? int'(e[15:0]) : 0);
      t0 = tx_n; r0 = rx_n;
      start_xfer(dir, nd, e[31:16], e[15:0], aa, ab);
      wait_idle();
      nw = 0;
      for (int k = 0; k < int'(e[31:16]) / 4; k++) begin
        if (!dir && tx_log[8'(t0 + nw)] !== pat(aa + 32'(k * 4))) nw = 1000;
        else if (dir && mem[10'((aa >> 2) + k)] !== 32'hBEEF_0000 + 32'(r0 + nw)) nw = 1000;
        else nw++;
      end
      if (nd == 2 && nw < 1000)
        for (int k = 0; k < int'(e[15:0]) / 4; k++) begin
          if (!dir && tx_log[8'(t0 + nw)] !== pat(ab + 32'(k * 4))) nw = 1000;
          else if (dir && mem[10'((ab >> 2) + k)] !== 32'hBEEF_0000 + 32'(r0 + nw)) nw = 1000;
          else nw++;
        end
      chk("R5 R6 data order", 32'(nw), 32'(tot / 4));
      chk("R6 words moved", dir ? 32'(rx_n - r0) : 32'(tx_n - t0), 32'(tot / 4));
      rd(5, v); chk("R8 devcnt", v, 32'(tot));
      rd(6, v); chk("R8 memcnt", v, 32'(tot));
      rd(3, v); chk("R11 cur addr", v, (nd == 2 ? ab + 32'(e[15:0]) : aa + 32'(e[31:16])));
      rd(7, v); chk("R7 busy clear", v, {29'd0, dir, 2'b00});
      cmpl_chk("R7 completion", 32'hFFFF_FFFF);
    end

    // R4 zero length = 65536, byte-swapped high address
    stall = 0; t0 = tx_n;
    start_xfer(1'b0, 1, 16'd0, 16'd0, 32'h0010_0000, 32'h0);
    wait_idle();
    chk("R4 words", 32'(tx_n - t0), 32'd16384);
    chk("R4 last word", tx_last, pat(32'h0010_FFFC));
    rd(5, v); chk("R4 devcnt", v, 32'h10000);
    rd(3, v); chk("R11 cur after 64K", v, 32'h0011_0000);

    // R3 go while busy ignored
    stall = 1; t0 = tx_n;
    start_xfer(1'b0, 1, 16'h100, 16'd0, 32'h400, 32'h0);
    repeat (5) @(negedge clk);
    wr(7, 32'h5);
    rd(7, v); chk("R3 busy dir kept", v & 32'hC, 32'h8);
    wait_idle();
    chk("R3 transfer intact", 32'(tx_n - t0), 32'd64);

    // R9 stop mid transfer
    r0 = rx_n;
    start_xfer(1'b1, 1, 16'h100, 16'd0, 32'h800, 32'h0);
    repeat (10) @(negedge clk);
    wr(7, 32'h6);
    rd(7, v); chk("R9 stop pending", v & 32'hA, 32'hA);
    wait_idle();
    rd(7, v); chk("R9 stop cleared", v & 32'hA, 0);
    rd(5, v); tot = int'(v);
    rd(6, v); chk("R8 counts equal after stop", v, 32'(tot));
    chk("R9 halted early", 32'(tot < 256), 1);
    cmpl_chk("R9 completion", 32'hFFFF_FFFF);

    // R10 memory error
    stall = 0; err_addr = 32'h404;
    start_xfer(1'b0, 1, 16'd16, 16'd0, 32'h400, 32'h0);
    wait_idle();
    rd(7, v); chk("R10 fault set", v & 32'h18, 32'h10);
    rd(6, v); chk("R10 memcnt", v, 32'd4);
    cmpl_chk("R10 no completion", 32'h0);
    wr(7, 32'h0);
    rd(7, v); chk("R10 fault cleared", v & 32'h10, 0);
    err_addr = 32'hFFFF_FFF0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 195000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule